// File: doc/BRIEF.md
# Fuse Word Read Controller

This block reads one 32-bit word at a time out of a one-time-programmable fuse array. Software reaches it through a 32-bit register window: a control register, which also appears at two further offsets that set or clear bits, a timing register, a read-trigger register and a read-data register. The fuse array is modelled as a parameterised internal ROM. Fuse programming and shadow reload are not built.

A read begins when the value 1 is written to the trigger offset. The block then runs a three-phase strobe sequence. A pre-relax phase comes first, then the read strobe, then a post-relax phase. The length of each phase comes from the timing register, and the busy flag stays high for the whole sequence. When the sequence ends, the fetched word appears at the read-data offset. A failed read sets a sticky error flag and leaves a fixed poison word in the read-data register instead.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where it is sampled, and read data comes combinationally from the address. Nothing flows as a stream, so the port has no valid/ready handshake and no back-pressure. Software polls the busy bit.

Top module: `fuse_read_ctrl`

## Requirements
- R1: After reset, the control, timing and read-data registers all read 0, and `busy` and `fuse_strobe` are 0.
- R2: The control register sits at offset 0x00. Its fields are: address in bits [6:0], busy in bit 8, error in bit 9, reload in bit 10 and unlock in bits [31:16]. A write stores only the bits in mask 0xFFFF067F. Bit 8 reads the live busy state, and every other bit reads 0.
- R3: A write to 0x04 ORs the masked write data into the control register, and a write to 0x08 clears the control bits where the write data holds 1. Bit 8 is never affected. Both offsets read back the control register.
- R4: The timing register at 0x10 stores only bits [21:0]: strobe length s in [21:16], relax r in [15:12] and a program-strobe field in [11:0]. The other bits read 0.
- R5: Writing exactly 1 to 0x30 while idle with error clear starts a read. `busy` is then high for exactly (r+1)+(s+1)+(r+1) cycles. Writing any other value to 0x30 starts nothing.
- R6: `fuse_strobe` is high for exactly s+1 consecutive cycles. Before it, `busy` is high for r+1 cycles without the strobe, and r+1 such cycles follow it.
- R7: A successful read of address a < DEPTH (96 by default) leaves the word a*0x9E3779B9 + 0x01234567 (mod 2^32) at 0x40, and the error flag stays 0.
- R8: A read of an address >= DEPTH still runs the full sequence. At its end the error flag is set and 0x40 holds 0xBADABADA.
- R9: A trigger while busy, or while the error flag is set, starts nothing. From the next cycle the error flag is 1 and 0x40 holds 0xBADABADA. A read that completes while the error flag is set also returns 0xBADABADA.
- R10: The error flag is sticky. Only a write to 0x00 or to the clear alias can lower it.
- R11: The unlock field and the reload bit have no effect on reads. Offsets 0x20, 0x30 and all unmapped offsets read 0, and writes to 0x20 or 0x40 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| busy | output | 1 | High while a strobe sequence runs |
| fuse_strobe | output | 1 | Read strobe to the fuse array |

## Verification
The hardest state to reach is a second trigger that arrives during a sequence already in flight. In that case the rejected trigger and the later completion must both leave the poison word, and the busy length must not change. The bench gets there with a long programmed timing: it fires a second trigger a few cycles into the run, then triggers again once idle with the error flag still set. Random reads then sweep the relax and strobe lengths and addresses on both sides of the array depth. Each read checks the three phase lengths and the returned word.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int BUS_AW = 8;
  localparam logic [BUS_AW-1:0] OFF_CTRL  = 8'h00;
  localparam logic [BUS_AW-1:0] OFF_SET   = 8'h04;
  localparam logic [BUS_AW-1:0] OFF_CLR   = 8'h08;
  localparam logic [BUS_AW-1:0] OFF_TIM   = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_PROG  = 8'h20;
  localparam logic [BUS_AW-1:0] OFF_TRIG  = 8'h30;
  localparam logic [BUS_AW-1:0] OFF_RDATA = 8'h40;

  localparam int BIT_BUSY = 8;
  localparam int BIT_ERR  = 9;
  localparam logic [31:0] CTRL_WMASK = 32'hFFFF_067F;
  localparam logic [31:0] TIM_MASK   = 32'h003F_FFFF;
  localparam logic [31:0] POISON     = 32'hBADA_BADA;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_STRB, S_POST} seq_state_e;

  function automatic logic [31:0] rom_word(input int unsigned idx);
    return idx * 32'h9E37_79B9 + 32'h0123_4567;
  endfunction
endpackage

// File: rtl/fuse_rom.sv
module fuse_rom #(
  parameter int DEPTH = 96,
  parameter int AW    = 7
) (
  input  logic [AW-1:0] addr,
  output logic [31:0]   data
);
  logic [31:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = fuse_pkg::rom_word(i);
  end

  assign data = ({1'b0, addr} < (AW+1)'(DEPTH)) ? mem[addr] : '0;
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int DEPTH   = 96,
  parameter int AW      = 7,
  parameter int RELAX_W = 4,
  parameter int STRB_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [RELAX_W-1:0] relax_i,
  input  logic [STRB_W-1:0]  strb_i,
  output logic               busy_o,
  output logic               strobe_o,
  output logic               done_o,
  output logic               oob_o,
  output logic [31:0]        data_o
);
  localparam int CNT_W = (RELAX_W > STRB_W) ? RELAX_W : STRB_W;

  seq_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [RELAX_W-1:0] relax_q;
  logic [STRB_W-1:0]  strb_q;
  logic [AW-1:0]      addr_q;
  logic [31:0]        rom_data;

  fuse_rom #(.DEPTH(DEPTH), .AW(AW)) u_rom (.addr(addr_q), .data(rom_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      relax_q <= '0;
      strb_q  <= '0;
      addr_q  <= '0;
      data_o  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          state   <= S_PRE;
          cnt     <= CNT_W'(relax_i);
          relax_q <= relax_i;
          strb_q  <= strb_i;
          addr_q  <= addr_i;
        end
        S_PRE: if (cnt == '0) begin
          state <= S_STRB;
          cnt   <= CNT_W'(strb_q);
        end else cnt <= cnt - CNT_W'(1);
        S_STRB: if (cnt == '0) begin
          state  <= S_POST;
          cnt    <= CNT_W'(relax_q);
          data_o <= rom_data;
        end else cnt <= cnt - CNT_W'(1);
        default: if (cnt == '0) state <= S_IDLE;
                 else cnt <= cnt - CNT_W'(1);
      endcase
    end
  end

  assign busy_o   = (state != S_IDLE);
  assign strobe_o = (state == S_STRB);
  assign done_o   = (state == S_POST) && (cnt == '0);
  assign oob_o    = ({1'b0, addr_q} >= (AW+1)'(DEPTH));

  // R6: the strobe never opens a sequence and is always followed by relax
  assert_no_strobe_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !strobe_o);
  assert_relax_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> busy_o);
endmodule

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
#(
  parameter int AW      = 7,
  parameter int RELAX_W = 4,
  parameter int STRB_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic               oob_i,
  input  logic [31:0]        data_i,
  output logic               start_o,
  output logic [AW-1:0]      addr_o,
  output logic [RELAX_W-1:0] relax_o,
  output logic [STRB_W-1:0]  strb_o
);
  logic [31:0] ctrl_q, ctrl_d, tim_q, rdata_q, wmasked;
  logic wr_ctrl, wr_set, wr_clr, wr_tim, trig_fire, reject, fail;

  assign wmasked   = bus_wdata & CTRL_WMASK;
  assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_set    = bus_wr && (bus_addr == OFF_SET);
  assign wr_clr    = bus_wr && (bus_addr == OFF_CLR);
  assign wr_tim    = bus_wr && (bus_addr == OFF_TIM);
  assign trig_fire = bus_wr && (bus_addr == OFF_TRIG) && (bus_wdata == 32'd1);
  assign reject    = trig_fire && (busy_i || ctrl_q[BIT_ERR]);
  assign start_o   = trig_fire && !reject;
  assign fail      = oob_i || ctrl_q[BIT_ERR];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wmasked;
    if (wr_set)  ctrl_d = ctrl_q | wmasked;
    if (wr_clr)  ctrl_d = ctrl_q & ~wmasked;
    if (reject || (done_i && fail)) ctrl_d[BIT_ERR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tim_q   <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_tim) tim_q <= bus_wdata & TIM_MASK;
      if (reject || (done_i && fail)) rdata_q <= POISON;
      else if (done_i)                rdata_q <= data_i;
    end
  end

  assign addr_o  = ctrl_q[AW-1:0];
  assign relax_o = tim_q[12 +: RELAX_W];
  assign strb_o  = tim_q[16 +: STRB_W];

  always_comb begin
    case (bus_addr)
      OFF_CTRL, OFF_SET, OFF_CLR: begin
        bus_rdata = ctrl_q;
        bus_rdata[BIT_BUSY] = busy_i;
      end
      OFF_TIM:   bus_rdata = tim_q;
      OFF_RDATA: bus_rdata = rdata_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_start_when_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (!busy_i && !ctrl_q[BIT_ERR]));
  assert_oob_flags_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && oob_i) |=> (ctrl_q[BIT_ERR] && rdata_q == POISON));
  assert_collision_poison_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fire && busy_i) |=> (ctrl_q[BIT_ERR] && rdata_q == POISON));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[BIT_ERR] && !wr_ctrl && !wr_clr) |=> ctrl_q[BIT_ERR]);
endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl
  import fuse_pkg::*;
#(
  parameter int DEPTH   = 96,
  parameter int AW      = 7,
  parameter int RELAX_W = 4,
  parameter int STRB_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              fuse_strobe
);
  logic               start, done, oob;
  logic [31:0]        data;
  logic [AW-1:0]      addr;
  logic [RELAX_W-1:0] relax;
  logic [STRB_W-1:0]  strb;

  fuse_regs #(.AW(AW), .RELAX_W(RELAX_W), .STRB_W(STRB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy),
    .done_i(done), .oob_i(oob), .data_i(data), .start_o(start),
    .addr_o(addr), .relax_o(relax), .strb_o(strb));

  fuse_seq #(.DEPTH(DEPTH), .AW(AW), .RELAX_W(RELAX_W), .STRB_W(STRB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .relax_i(relax), .strb_i(strb), .busy_o(busy), .strobe_o(fuse_strobe),
    .done_o(done), .oob_o(oob), .data_o(data));
endmodule

// File: tb/tb_fuse_read_ctrl.sv
module tb_fuse_read_ctrl;
  localparam int DEPTH = 96;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic busy, fuse_strobe;
  int checks = 0, fails = 0;
  bit finished = 0;

  fuse_read_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .fuse_strobe(fuse_strobe));

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_word(input int unsigned a);
    if (a >= DEPTH) return 32'hBADA_BADA;
    return a * 32'h9E37_79B9 + 32'h0123_4567;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_read(input int unsigned a, input int unsigned r, input int unsigned s,
                         input logic [15:0] unlock);
    int n = 0, pre = 0, stb = 0;
    bit seen = 0;
    logic [31:0] v;
    wr(8'h10, (s << 16) | (r << 12));
    wr(8'h00, {unlock, 9'b0, a[6:0]});
    wr(8'h30, 32'd1);
    while (busy && n < 300) begin
      n++;
      if (fuse_strobe) begin stb++; seen = 1; end
      else if (!seen) pre++;
      @(negedge clk);
    end
    chk("R5 busy length", n, (r+1)+(s+1)+(r+1));
    chk("R6 pre-relax", pre, r+1);
    chk("R6 strobe length", stb, s+1);
    chk("R6 post-relax", n-pre-stb, r+1);
    rd(8'h40, v);
    chk(a < DEPTH ? "R7 data" : "R8 poison", v, exp_word(a));
    rd(8'h00, v);
    chk(a < DEPTH ? "R7 err clear" : "R8 err set", {31'b0, v[9]}, {31'b0, a >= DEPTH});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h10, v); chk("R1 timing", v, 0);
    rd(8'h40, v); chk("R1 rdata", v, 0);
    chk("R1 busy/strobe", {busy, fuse_strobe}, 0);

    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 ctrl mask", v, 32'hFFFF_067F);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R3 clear alias", v, 0);
    wr(8'h04, 32'h0000_0105); rd(8'h04, v); chk("R3 set alias", v, 32'h5);
    wr(8'h08, 32'h0000_0004); rd(8'h00, v); chk("R3 clear bit", v, 32'h1);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R4 timing mask", v, 32'h003F_FFFF);

    wr(8'h10, 0);
    wr(8'h30, 32'd2); chk("R5 non-1 trigger", busy, 0);
    rd(8'h40, v); chk("R5 no data change", v, 0);

    wr(8'h20, 32'h1234_5678); rd(8'h20, v); chk("R11 prog offset", v, 0);
    wr(8'h40, 32'h1111_1111); rd(8'h40, v); chk("R11 rdata read-only", v, 0);
    rd(8'h30, v); chk("R11 trigger reads 0", v, 0);
    rd(8'h7C, v); chk("R11 unmapped", v, 0);

    do_read(0, 0, 0, 16'h0);
    do_read(DEPTH-1, 2, 5, 16'h0);
    do_read(5, 1, 3, 16'h3E77);
    rd(8'h00, v); chk("R11 unlock readback", v[31:16], 16'h3E77);
    do_read(DEPTH, 0, 1, 16'h0);
    wr(8'h10, 32'h0001_0000); rd(8'h00, v); chk("R10 err sticky", v[9], 1);
    wr(8'h08, 32'h200); rd(8'h00, v); chk("R10 err cleared", v[9], 0);
    do_read(127, 15, 63, 16'h0);
    wr(8'h00, 32'h0);

    wr(8'h10, (32'd20 << 16) | (32'd3 << 12));
    wr(8'h00, 32'd7);
    wr(8'h30, 32'd1);
    @(negedge clk);
    wr(8'h30, 32'd1);
    rd(8'h40, v); chk("R9 collision poison", v, 32'hBADA_BADA);
    rd(8'h00, v); chk("R9 collision err", v[9:8], 2'b11);
    while (busy) @(negedge clk);
    rd(8'h40, v); chk("R9 in-flight poisoned", v, 32'hBADA_BADA);
    wr(8'h30, 32'd1); chk("R9 no start when err", busy, 0);
    wr(8'h00, 32'd7); rd(8'h00, v); chk("R10 direct write clears err", v[9], 0);
    do_read(7, 0, 0, 16'h0);

    for (int i = 0; i < 40; i++) begin
      int unsigned a = $urandom_range(127, 0);
      do_read(a, $urandom_range(15, 0), $urandom_range(63, 0), 16'($urandom));
      if (a >= DEPTH) wr(8'h08, 32'h200);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule